// File: doc/BRIEF.md
# Serial EEPROM Configuration Loader

This block moves board setup words between a three-wire serial EEPROM of 64 sixteen-bit words and a small set of on-chip registers. These are a configuration word, a base word, three station-address words and one general-purpose word. All EEPROM addressing is in whole words. Three strap inputs choose where the configuration and base words live in the EEPROM. This lets identical boards in one system each take their own setup. The station-address words always sit at fixed locations.

The host sees a control register with a select bit, a reload bit and a store bit, a 6-bit pointer register, and write access to the general-purpose, configuration and base words. A load runs by itself after reset, and again whenever the host sets reload. Setting store writes register contents back to the EEPROM. With select clear, these bits move the bulk setup words. With select set, they move one word between the general-purpose register and the EEPROM address held in the pointer. Reload and store stay high while the transfer runs and clear themselves at the end, so the host polls them for completion. A divider derives the serial clock from the system clock.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: After reset the control bits read select=0, reload=1, store=0. The block then loads the configuration word from EEPROM word strap×4, the base word from strap×4+1, and the three station-address words from words 0x20, 0x21 and 0x22. `addr_o` packs them as {0x22, 0x21, 0x20}. When the load completes, reload reads 0.
- R2: With strap value 7, a bulk load reads only the station-address words. The configuration and base words keep their previous values, which after reset are CFG_RST and BASE_RST.
- R3: A control write with bit 2 (select) = 1 and bit 1 (reload) = 1 copies EEPROM word pointer[5:0] into the general-purpose register. No other register changes.
- R4: A control write with select = 0 and bit 0 (store) = 1 writes the configuration word to EEPROM word strap×4 and the base word to strap×4+1. No other EEPROM word changes.
- R5: A control write with select = 1 and store = 1 writes the general-purpose register to EEPROM word pointer[5:0].
- R6: Reload and store stay high for the whole transfer and clear themselves when it ends. Select keeps its written value. Chip select is only active while reload or store is high.
- R7: While reload or store is high, every host write is ignored. This covers the pointer, select, the data words and new commands.
- R8: Each serial frame starts with chip select high and a start bit of 1. Then come a 2-bit opcode (10 read, 01 write, 00 with address 11xxxx write-enable), a 6-bit address and 16 data bits, all most significant bit first. The data line changes only while the serial clock is low, and the serial clock stays low while chip select is low.
- R9: A store sends one write-enable frame before its first write frame. After each write it drops chip select, raises it again, and waits for the EEPROM data-out line to go high before continuing.
- R10: If data-out never goes high after a write, the wait ends after TMO_TICKS serial half-periods and the store still completes.
- R11: A control write with both reload and store set runs a reload only. Store reads 0 from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_i | input | 3 | Board strap value selecting the setup word location |
| reg_wr_i | input | 1 | Host register write strobe |
| reg_addr_i | input | 3 | Register code: 0 control, 1 pointer, 2 general-purpose, 3 configuration, 4 base |
| reg_wdata_i | input | 16 | Host write data |
| ctl_o | output | 3 | Control bits {select, reload, store} |
| ptr_o | output | 6 | Pointer register |
| gp_o | output | 16 | General-purpose register |
| cfg_o | output | 16 | Configuration register |
| base_o | output | 16 | Base register |
| addr_o | output | 48 | Station-address registers {word 0x22, 0x21, 0x20} |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | Serial data to the EEPROM |
| ee_do_i | input | 1 | Serial data and ready status from the EEPROM |

## Verification
The assertions check the serial line discipline on every cycle: the serial clock is quiet while chip select is low, and data holds still while the clock is high. They also check that chip select never rises outside a transfer, that reload and store are never both high, and that a busy transfer keeps the pointer and select unchanged. Only the bench scenarios can show that the right words land in the right registers and EEPROM locations. The same holds for the strap sweep, the skipped words for strap 7, the write-enable before writes, the ready wait and its timeout.

// File: rtl/eecfg_pkg.sv
package eecfg_pkg;
  localparam int EE_AW = 6;
  localparam int EE_DW = 16;

  typedef enum logic [1:0] {
    OP_WEN   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10
  } ee_op_e;

  typedef enum logic [1:0] {
    JOB_LOAD_ALL,
    JOB_LOAD_GP,
    JOB_STORE_ALL,
    JOB_STORE_GP
  } job_e;

  typedef enum logic [2:0] {
    DST_NONE, DST_CFG, DST_BASE, DST_IA0, DST_IA1, DST_IA2, DST_GP
  } dst_e;

  typedef struct packed {
    ee_op_e           op;
    logic [EE_AW-1:0] addr;
    dst_e             dst;
    logic             last;
  } step_t;

  localparam logic [2:0] RA_CTL  = 3'd0;
  localparam logic [2:0] RA_PTR  = 3'd1;
  localparam logic [2:0] RA_GP   = 3'd2;
  localparam logic [2:0] RA_CFG  = 3'd3;
  localparam logic [2:0] RA_BASE = 3'd4;
endpackage

// File: rtl/eecfg_tick.sv
module eecfg_tick #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int CW = (DIV < 2) ? 1 : $clog2(DIV);
  localparam logic [CW-1:0] TOP = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick_o = (cnt_q == TOP);
    cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/eecfg_serial.sv
module eecfg_serial
  import eecfg_pkg::*;
#(
  parameter int TMO_TICKS = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             start_i,
  input  ee_op_e           op_i,
  input  logic [EE_AW-1:0] addr_i,
  input  logic [EE_DW-1:0] wdata_i,
  output logic             done_o,
  output logic [EE_DW-1:0] rdata_o,
  output logic             cs_o,
  output logic             sk_o,
  output logic             di_o,
  input  logic             do_i
);
  localparam int HDR = 3 + EE_AW;
  localparam int FW  = HDR + EE_DW;
  localparam int CW  = $clog2(FW + 1);
  localparam int TW  = $clog2(TMO_TICKS + 1);
  localparam logic [CW-1:0] HDR_C     = CW'(HDR);
  localparam logic [CW-1:0] LAST_WEN  = CW'(HDR - 1);
  localparam logic [CW-1:0] LAST_FULL = CW'(FW - 1);
  localparam logic [TW-1:0] TMO_LAST  = TW'(TMO_TICKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_GAP, S_READY, S_END} st_e;

  st_e              st_q, st_d;
  logic [FW-1:0]    sh_q, sh_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [TW-1:0]    tmo_q, tmo_d;
  logic [EE_DW-1:0] rd_q, rd_d;
  ee_op_e           op_q, op_d;
  logic             ph_q, ph_d, cs_q, cs_d, sk_q, sk_d, di_q, di_d;
  logic [CW-1:0]    last_cnt;

  always_comb begin
    st_d = st_q; sh_d = sh_q; cnt_d = cnt_q; tmo_d = tmo_q; rd_d = rd_q;
    op_d = op_q; ph_d = ph_q; cs_d = cs_q; sk_d = sk_q; di_d = di_q;
    done_o   = 1'b0;
    last_cnt = (op_q == OP_WEN) ? LAST_WEN : LAST_FULL;
    unique case (st_q)
      S_IDLE: if (start_i) begin
        sh_d  = {1'b1, op_i, addr_i, wdata_i};
        op_d  = op_i;
        cnt_d = '0;
        ph_d  = 1'b0;
        cs_d  = 1'b1;
        sk_d  = 1'b0;
        st_d  = S_SHIFT;
      end
      S_SHIFT: if (tick_i) begin
        if (!ph_q) begin
          sk_d = 1'b0;
          di_d = sh_q[FW-1];
          ph_d = 1'b1;
        end else begin
          sk_d  = 1'b1;
          ph_d  = 1'b0;
          sh_d  = {sh_q[FW-2:0], 1'b0};
          cnt_d = cnt_q + 1'b1;
          if (cnt_q >= HDR_C) rd_d = {rd_q[EE_DW-2:0], do_i};
          if (cnt_q == last_cnt) st_d = S_GAP;
        end
      end
      S_GAP: if (tick_i) begin
        sk_d  = 1'b0;
        cs_d  = 1'b0;
        di_d  = 1'b0;
        tmo_d = '0;
        st_d  = (op_q == OP_WRITE) ? S_READY : S_END;
      end
      S_READY: if (tick_i) begin
        if (cs_q && (do_i || tmo_q == TMO_LAST)) begin
          cs_d = 1'b0;
          st_d = S_END;
        end else begin
          cs_d  = 1'b1;
          tmo_d = tmo_q + 1'b1;
        end
      end
      S_END: begin
        done_o = 1'b1;
        st_d   = S_IDLE;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; sh_q <= '0; cnt_q <= '0; tmo_q <= '0; rd_q <= '0;
      op_q <= OP_READ; ph_q <= 1'b0; cs_q <= 1'b0; sk_q <= 1'b0; di_q <= 1'b0;
    end else begin
      st_q <= st_d; sh_q <= sh_d; cnt_q <= cnt_d; tmo_q <= tmo_d; rd_q <= rd_d;
      op_q <= op_d; ph_q <= ph_d; cs_q <= cs_d; sk_q <= sk_d; di_q <= di_d;
    end
  end

  assign rdata_o = rd_q;
  assign cs_o    = cs_q;
  assign sk_o    = sk_q;
  assign di_o    = di_q;
endmodule

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader
  import eecfg_pkg::*;
#(
  parameter int          CLK_DIV   = 4,
  parameter int          TMO_TICKS = 4096,
  parameter logic [15:0] CFG_RST   = 16'h0000,
  parameter logic [15:0] BASE_RST  = 16'h0300
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  strap_i,
  input  logic        reg_wr_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [2:0]  ctl_o,
  output logic [5:0]  ptr_o,
  output logic [15:0] gp_o,
  output logic [15:0] cfg_o,
  output logic [15:0] base_o,
  output logic [47:0] addr_o,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_di_o,
  input  logic        ee_do_i
);
  typedef enum logic [1:0] {Q_IDLE, Q_START, Q_ISSUE, Q_WAIT} seq_e;

  logic [1:0] rsync_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  seq_e             qst_q, qst_d;
  job_e             job_q, job_d;
  logic [2:0]       step_q, step_d;
  logic [EE_DW-1:0] cfg_q, cfg_d, base_q, base_d, gp_q, gp_d;
  logic [EE_DW-1:0] ia0_q, ia0_d, ia1_q, ia1_d, ia2_q, ia2_d;
  logic [EE_AW-1:0] ptr_q, ptr_d;
  logic             sel_q, sel_d, rld_q, rld_d, sto_q, sto_d;

  logic             tick, start, done;
  logic [EE_DW-1:0] rdata, wdata;
  step_t            cur;

  function automatic step_t plan_step(job_e j, logic [2:0] s, logic [2:0] strap,
                                      logic [EE_AW-1:0] ptr);
    step_t r;
    r = '{op: OP_READ, addr: '0, dst: DST_NONE, last: 1'b1};
    unique case (j)
      JOB_LOAD_ALL: unique case (s)
        3'd0:    r = '{OP_READ, {strap, 2'b00}, DST_CFG,  1'b0};
        3'd1:    r = '{OP_READ, {strap, 2'b01}, DST_BASE, 1'b0};
        3'd2:    r = '{OP_READ, 6'h20,          DST_IA0,  1'b0};
        3'd3:    r = '{OP_READ, 6'h21,          DST_IA1,  1'b0};
        default: r = '{OP_READ, 6'h22,          DST_IA2,  1'b1};
      endcase
      JOB_LOAD_GP:   r = '{OP_READ, ptr, DST_GP, 1'b1};
      JOB_STORE_ALL: unique case (s)
        3'd0:    r = '{OP_WEN,   6'h30,          DST_NONE, 1'b0};
        3'd1:    r = '{OP_WRITE, {strap, 2'b00}, DST_CFG,  1'b0};
        default: r = '{OP_WRITE, {strap, 2'b01}, DST_BASE, 1'b1};
      endcase
      default: r = (s == 3'd0) ? '{OP_WEN, 6'h30, DST_NONE, 1'b0}
                               : '{OP_WRITE, ptr, DST_GP, 1'b1};
    endcase
    return r;
  endfunction

  always_comb begin
    cur = plan_step(job_q, step_q, strap_i, ptr_q);
    unique case (cur.dst)
      DST_CFG:  wdata = cfg_q;
      DST_BASE: wdata = base_q;
      default:  wdata = gp_q;
    endcase
  end

  always_comb begin
    qst_d = qst_q; job_d = job_q; step_d = step_q;
    cfg_d = cfg_q; base_d = base_q; gp_d = gp_q;
    ia0_d = ia0_q; ia1_d = ia1_q; ia2_d = ia2_q; ptr_d = ptr_q;
    sel_d = sel_q; rld_d = rld_q; sto_d = sto_q;
    start = 1'b0;
    unique case (qst_q)
      Q_IDLE: if (reg_wr_i) begin
        unique case (reg_addr_i)
          RA_CTL: begin
            sel_d = reg_wdata_i[2];
            rld_d = reg_wdata_i[1];
            sto_d = reg_wdata_i[0] & ~reg_wdata_i[1];
            if (reg_wdata_i[1] | reg_wdata_i[0]) begin
              qst_d = Q_START;
              if (reg_wdata_i[1]) job_d = reg_wdata_i[2] ? JOB_LOAD_GP  : JOB_LOAD_ALL;
              else                job_d = reg_wdata_i[2] ? JOB_STORE_GP : JOB_STORE_ALL;
            end
          end
          RA_PTR:  ptr_d  = reg_wdata_i[EE_AW-1:0];
          RA_GP:   gp_d   = reg_wdata_i;
          RA_CFG:  cfg_d  = reg_wdata_i;
          RA_BASE: base_d = reg_wdata_i;
          default: ;
        endcase
      end
      Q_START: begin
        step_d = (job_q == JOB_LOAD_ALL && strap_i == 3'd7) ? 3'd2 : 3'd0;
        qst_d  = Q_ISSUE;
      end
      Q_ISSUE: begin
        start = 1'b1;
        qst_d = Q_WAIT;
      end
      Q_WAIT: if (done) begin
        if (cur.op == OP_READ) begin
          unique case (cur.dst)
            DST_CFG:  cfg_d  = rdata;
            DST_BASE: base_d = rdata;
            DST_IA0:  ia0_d  = rdata;
            DST_IA1:  ia1_d  = rdata;
            DST_IA2:  ia2_d  = rdata;
            DST_GP:   gp_d   = rdata;
            default:  ;
          endcase
        end
        if (cur.last) begin
          rld_d = 1'b0;
          sto_d = 1'b0;
          qst_d = Q_IDLE;
        end else begin
          step_d = step_q + 1'b1;
          qst_d  = Q_ISSUE;
        end
      end
      default: qst_d = Q_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      qst_q <= Q_START; job_q <= JOB_LOAD_ALL; step_q <= '0;
      cfg_q <= CFG_RST; base_q <= BASE_RST; gp_q <= '0;
      ia0_q <= '0; ia1_q <= '0; ia2_q <= '0; ptr_q <= '0;
      sel_q <= 1'b0; rld_q <= 1'b1; sto_q <= 1'b0;
    end else begin
      qst_q <= qst_d; job_q <= job_d; step_q <= step_d;
      cfg_q <= cfg_d; base_q <= base_d; gp_q <= gp_d;
      ia0_q <= ia0_d; ia1_q <= ia1_d; ia2_q <= ia2_d; ptr_q <= ptr_d;
      sel_q <= sel_d; rld_q <= rld_d; sto_q <= sto_d;
    end
  end

  eecfg_tick #(.DIV(CLK_DIV)) tick_i (
    .clk(clk), .rst_n(srst_n), .tick_o(tick)
  );

  eecfg_serial #(.TMO_TICKS(TMO_TICKS)) ser_i (
    .clk(clk), .rst_n(srst_n), .tick_i(tick), .start_i(start),
    .op_i(cur.op), .addr_i(cur.addr), .wdata_i(wdata),
    .done_o(done), .rdata_o(rdata),
    .cs_o(ee_cs_o), .sk_o(ee_sk_o), .di_o(ee_di_o), .do_i(ee_do_i)
  );

  assign ctl_o  = {sel_q, rld_q, sto_q};
  assign ptr_o  = ptr_q;
  assign gp_o   = gp_q;
  assign cfg_o  = cfg_q;
  assign base_o = base_q;
  assign addr_o = {ia2_q, ia1_q, ia0_q};
endmodule

// File: rtl/eeprom_cfg_loader_chk.sv
module eeprom_cfg_loader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr_i,
  input logic [2:0] ctl_o,
  input logic [5:0] ptr_o,
  input logic       ee_cs_o,
  input logic       ee_sk_o,
  input logic       ee_di_o
);
  // R8
  sk_idle_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ee_cs_o |-> !ee_sk_o);

  // R8
  di_hold_while_sk_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ee_sk_o && $past(ee_sk_o)) |-> (ee_di_o == $past(ee_di_o)));

  // R6
  cs_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ee_cs_o |-> (ctl_o[1] || ctl_o[0]));

  // R6
  reload_rises_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl_o[1]) |-> $past(reg_wr_i));

  // R11
  reload_store_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_o[1] && ctl_o[0]));

  // R7
  busy_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctl_o[1] || ctl_o[0]) && reg_wr_i) |=> ($stable(ptr_o) && $stable(ctl_o[2])));
endmodule

bind eeprom_cfg_loader eeprom_cfg_loader_chk chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .ctl_o(ctl_o), .ptr_o(ptr_o),
  .ee_cs_o(ee_cs_o), .ee_sk_o(ee_sk_o), .ee_di_o(ee_di_o)
);

// File: tb/eeprom_cfg_loader_tb_top.sv
module eeprom_cfg_loader_tb_top;
  localparam logic [15:0] CFG_RST  = 16'h1234;
  localparam logic [15:0] BASE_RST = 16'h0300;
  localparam int          TMO      = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  strap;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [2:0]  ctl;
  logic [5:0]  ptr;
  logic [15:0] gp, cfg, base;
  logic [47:0] ia;
  logic        ee_cs, ee_sk, ee_di, ee_do;

  always #4 clk = ~clk;

  eeprom_cfg_loader #(.CLK_DIV(2), .TMO_TICKS(TMO), .CFG_RST(CFG_RST), .BASE_RST(BASE_RST)) dut_i (
    .clk(clk), .rst_n(rst_n), .strap_i(strap), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .ctl_o(ctl), .ptr_o(ptr), .gp_o(gp), .cfg_o(cfg),
    .base_o(base), .addr_o(ia), .ee_cs_o(ee_cs), .ee_sk_o(ee_sk), .ee_di_o(ee_di),
    .ee_do_i(ee_do)
  );

  // EEPROM stand-in, evaluated on the falling system clock edge
  logic [15:0] mem [64];
  logic [15:0] exp_mem [64];
  logic [8:0]  hdr;
  logic [15:0] rdsh, wsh;
  logic [5:0]  waddr;
  int          nb, wb, busy, mode, wen_cnt, bad_start;
  logic        wen, rd_bit, sk_p, cs_p, stuck;

  assign ee_do = stuck ? 1'b0 : ((busy != 0) ? 1'b0 : rd_bit);

  always @(negedge clk) begin
    if (busy > 0) busy <= busy - 1;
    if (ee_cs && !cs_p) begin
      nb = 0; wb = 0; hdr = '0; mode = 1;
    end
    if (ee_cs && ee_sk && !sk_p) begin
      if (mode == 1) begin
        hdr = {hdr[7:0], ee_di};
        nb = nb + 1;
        if (nb == 9) begin
          if (!hdr[8]) bad_start++;
          waddr = hdr[5:0];
          if (hdr[7:6] == 2'b10) begin mode = 2; rdsh = mem[hdr[5:0]]; end
          else if (hdr[7:6] == 2'b01) mode = 3;
          else begin
            if (hdr[5:4] == 2'b11) begin wen = 1'b1; wen_cnt++; end
            mode = 0;
          end
        end
      end else if (mode == 3 && wb < 16) begin
        wsh = {wsh[14:0], ee_di};
        wb = wb + 1;
      end
    end
    if (ee_cs && !ee_sk && sk_p && mode == 2) begin
      rd_bit = rdsh[15];
      rdsh = {rdsh[14:0], 1'b0};
    end
    if (!ee_cs && cs_p) begin
      if (mode == 3 && wb == 16 && wen) begin
        mem[waddr] = wsh;
        busy <= 20;
      end
      mode = 0;
      rd_bit = 1'b1;
    end
    sk_p = ee_sk;
    cs_p = ee_cs;
  end

  int tests = 0, fails = 0, cyc = 0;
  bit finished = 0;

  function automatic logic [15:0] init_word(int i);
    return 16'h5A00 ^ 16'(i * 16'h0347);
  endfunction

  task automatic check(bit ok, string tag, logic [47:0] act, logic [47:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic host_wr(logic [2:0] a, logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle(int limit, output bit ok);
    ok = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ctl[1:0] == 2'b00) begin ok = 1'b1; break; end
    end
  endtask

  task automatic do_reset(logic [2:0] s);
    strap = s; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  function automatic int mem_diffs();
    int n = 0;
    for (int i = 0; i < 64; i++) if (mem[i] !== exp_mem[i]) n++;
    return n;
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !finished) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    bit ok;
    logic [47:0] exp_ia;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0; stuck = 0; wen = 0;
    busy = 0; mode = 0; wen_cnt = 0; bad_start = 0; rd_bit = 1; sk_p = 0; cs_p = 0;
    for (int i = 0; i < 64; i++) begin mem[i] = init_word(i); exp_mem[i] = init_word(i); end
    exp_ia = {init_word(34), init_word(33), init_word(32)};

    // R1 / R2: strap sweep of the automatic load
    for (int s = 0; s < 8; s++) begin
      do_reset(3'(s));
      check(ctl == 3'b010, $sformatf("R1 ctl after reset strap=%0d", s), 48'(ctl), 48'h2);
      wait_idle(5000, ok);
      check(ok, "R1 load completes", 48'(ok), 48'h1);
      check(cfg == ((s == 7) ? CFG_RST : init_word(s * 4)),
            $sformatf("R1/R2 cfg strap=%0d", s), 48'(cfg),
            48'((s == 7) ? CFG_RST : init_word(s * 4)));
      check(base == ((s == 7) ? BASE_RST : init_word(s * 4 + 1)),
            $sformatf("R1/R2 base strap=%0d", s), 48'(base),
            48'((s == 7) ? BASE_RST : init_word(s * 4 + 1)));
      check(ia == exp_ia, $sformatf("R1 station address strap=%0d", s), ia, exp_ia);
    end

    // R3: single-word reload over every pointer value
    do_reset(3'd2);
    wait_idle(5000, ok);
    for (int a = 0; a < 64; a++) begin
      host_wr(3'd1, 16'(a));
      host_wr(3'd0, 16'b110);
      wait_idle(2000, ok);
      check(gp == init_word(a), $sformatf("R3 gp ptr=%0d", a), 48'(gp), 48'(init_word(a)));
      check(cfg == init_word(8), "R3 cfg untouched", 48'(cfg), 48'(init_word(8)));
    end
    check(ctl == 3'b100, "R6 select kept, bits cleared", 48'(ctl), 48'h4);

    // R7: writes during a busy reload are ignored
    host_wr(3'd1, 16'd5);
    host_wr(3'd0, 16'b110);
    host_wr(3'd1, 16'd9);
    host_wr(3'd0, 16'b001);
    host_wr(3'd3, 16'hDEAD);
    wait_idle(2000, ok);
    check(ptr == 6'd5, "R7 pointer held", 48'(ptr), 48'd5);
    check(ctl == 3'b100, "R7 select held", 48'(ctl), 48'h4);
    check(cfg == init_word(8), "R7 cfg held", 48'(cfg), 48'(init_word(8)));
    check(gp == init_word(5), "R7 reload result", 48'(gp), 48'(init_word(5)));

    // R5 / R9: single-word store
    wen = 0;
    host_wr(3'd1, 16'd40);
    host_wr(3'd2, 16'hBEEF);
    host_wr(3'd0, 16'b101);
    wait_idle(3000, ok);
    exp_mem[40] = 16'hBEEF;
    check(ok && ctl[0] == 1'b0, "R6 store self-clears", 48'(ctl), 48'h4);
    check(mem[40] == 16'hBEEF, "R5/R9 gp stored", 48'(mem[40]), 48'hBEEF);
    check(mem_diffs() == 0, "R5 other words untouched", 48'(mem_diffs()), 48'd0);
    check(wen_cnt == 1, "R9 one write-enable", 48'(wen_cnt), 48'd1);
    host_wr(3'd2, 16'h0000);
    host_wr(3'd0, 16'b110);
    wait_idle(2000, ok);
    check(gp == 16'hBEEF, "R5 read back", 48'(gp), 48'hBEEF);

    // R4 / R9: bulk store with strap 3
    do_reset(3'd3);
    wait_idle(5000, ok);
    wen = 0;
    host_wr(3'd3, 16'hC0DE);
    host_wr(3'd4, 16'hBA5E);
    host_wr(3'd0, 16'b001);
    wait_idle(4000, ok);
    exp_mem[12] = 16'hC0DE; exp_mem[13] = 16'hBA5E;
    check(mem[12] == 16'hC0DE, "R4 cfg word stored", 48'(mem[12]), 48'hC0DE);
    check(mem[13] == 16'hBA5E, "R4 base word stored", 48'(mem[13]), 48'hBA5E);
    check(mem_diffs() == 0, "R4 other words untouched", 48'(mem_diffs()), 48'd0);
    check(wen_cnt == 2, "R9 write-enable per store", 48'(wen_cnt), 48'd2);

    // R11: reload and store together run the reload only
    host_wr(3'd3, 16'h7777);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 16'b011;
    @(negedge clk);
    reg_wr = 1'b0;
    check(ctl == 3'b010, "R11 store dropped", 48'(ctl), 48'h2);
    wait_idle(5000, ok);
    check(cfg == 16'hC0DE, "R11 cfg reloaded", 48'(cfg), 48'hC0DE);
    check(mem_diffs() == 0, "R11 nothing written", 48'(mem_diffs()), 48'd0);

    // R10: ready never comes, the wait times out
    stuck = 1;
    host_wr(3'd1, 16'd50);
    host_wr(3'd2, 16'h4242);
    host_wr(3'd0, 16'b101);
    wait_idle(TMO * 2 + 600, ok);
    check(ok, "R10 store ends after timeout", 48'(ctl), 48'h4);
    stuck = 0;

    check(bad_start == 0, "R8 start bit present in every frame", 48'(bad_start), 48'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule